// File: doc/BRIEF.md
# Interrupt Arbitration and Vector Sequencer

This block sits next to a small 8-bit processor core and decides when control moves to an interrupt handler and which handler it moves to. It keeps the core's interrupt-mask bit. It watches the pending flags and enables of four hardware sources and a software-interrupt request from the decoder. Requests are acted on only when the core signals that an instruction has finished, so no instruction is cut short.

When a request is accepted, the sequencer asks the core to stack its registers and waits for the core to report that stacking is done. It then sets the mask bit and picks the winning source from the flags as they stand at that moment. Last, it presents the two byte addresses of that source's vector on two consecutive cycles, with a one-hot grant. Reset bypasses the instruction boundary and vectors straight away. A return-from-interrupt strobe loads the mask from the stacked copy, and a clear strobe lets the core unmask.

Top module: `irq_vec_seq`

## Requirements
- R1: While the synchronous reset is high, and on the cycle after it is released, the block drives vector address 0x3FFE with `vec_valid` high and `grant` bit 0 set. On the next cycle it drives 0x3FFF. After that it is idle with `vec_valid` low. `cpu_mask` reads 1 out of reset.
- R2: A request is sampled only on a clock edge where `insn_end` is high. Pending, enabled sources with the mask clear never raise `stack_req` without `insn_end`.
- R3: A hardware source is accepted only when `cpu_mask` is 0 and its enable is 1. Otherwise `stack_req` stays low.
- R4: `swi_req` at an instruction boundary is accepted whatever the value of `cpu_mask`.
- R5: `stack_req` goes high on the cycle after the accepting edge and stays high until `stack_done` is sampled. `mask_set` is high for exactly the cycle that follows.
- R6: The winner is picked from the sources pending after stacking, highest vector address first. A source that becomes pending during stacking can win.
- R7: A source whose flag drops during stacking is left out. If no enabled source is pending after stacking, the source that was highest at the boundary is vectored.
- R8: The display-channel request is the OR of the five `disp_flags` bits, each ANDed with the matching `disp_en` bit. The timer request is the same over the two `tmr_flags` bits and `tmr_en`.
- R9: The vector addresses and grant bits are: software 0x3FFC (bit 1), external 0x3FFA (bit 2), sync 0x3FF8 (bit 3), display channel 0x3FF6 (bit 4), timer 0x3FF4 (bit 5). `grant` is one-hot while `vec_valid` is high.
- R10: The even address is driven for one cycle, then the odd address (base+1) on the next cycle, each with `vec_valid` high and the same grant.
- R11: While idle, `rti_strobe` loads `cpu_mask` from `rti_mask`, and `mask_clr` clears it.
- R12: `cpu_mask` is 1 from the cycle after `mask_set` until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_end | input | 1 | Instruction-completion pulse |
| cpu_mask | output | 1 | Interrupt-mask bit |
| mask_clr | input | 1 | Clear the mask bit |
| rti_strobe | input | 1 | Return-from-interrupt strobe |
| rti_mask | input | 1 | Stacked mask value to restore |
| swi_req | input | 1 | Software-interrupt request |
| ext_pend | input | 1 | External line pending |
| ext_en | input | 1 | External line enable |
| sync_pend | input | 1 | Sync-processor pending |
| sync_en | input | 1 | Sync-processor enable |
| disp_flags | input | DSC_N | Display-channel event flags |
| disp_en | input | DSC_N | Display-channel enables |
| tmr_flags | input | TMR_N | Timer event flags |
| tmr_en | input | TMR_N | Timer enables |
| stack_req | output | 1 | Request to stack the core registers |
| stack_done | input | 1 | Stacking complete |
| mask_set | output | 1 | Mask-set strobe |
| vec_valid | output | 1 | Vector fetch address valid |
| vec_addr | output | ADDR_W | Vector fetch address |
| grant | output | NSRC | One-hot winning source |

## Verification
A bad state register shows up at the ports within one or two cycles as a missing or held `stack_req`, a `mask_set` that does not follow `stack_done`, or a vector pair that is out of order or the wrong length. A wrong latched or arbitrated source shows up as a wrong address and grant on the first vector cycle. The bench moves flags during the stacking wait to separate arbitration at the boundary from arbitration after stacking. A mask-register fault shows up as acceptance with the mask set, or a refusal with it clear, on the next boundary.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [2:0] {
      S_RST_HI, S_RST_LO, S_IDLE, S_STACK, S_MASK, S_VEC_HI, S_VEC_LO
   } seq_state_t;

   localparam int NSRC    = 6;
   localparam int SRC_RST = 0;
   localparam int SRC_SWI = 1;
   localparam int SRC_EXT = 2;
   localparam int SRC_SYN = 3;
   localparam int SRC_DSC = 4;
   localparam int SRC_TMR = 5;
endpackage

// File: rtl/irq_flag_merge.sv
module irq_flag_merge #(
   parameter int N = 5
) (
   input  logic [N-1:0] flags,
   input  logic [N-1:0] en,
   output logic         req
);
   generate
      if (N < 1) begin : g_bad
         $error("irq_flag_merge: N must be at least 1");
      end else if (N == 1) begin : g_single
         assign req = flags[0] & en[0];
      end else begin : g_multi
         assign req = |(flags & en);
      end
   endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N = 6
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] onehot,
   output logic         any
);
   generate
      if (N < 2) begin : g_bad
         $error("irq_prio_pick: N must be at least 2");
      end
   endgenerate

   always_comb begin
      onehot = '0;
      any    = 1'b0;
      for (int k = 0; k < N; k++) begin
         if (req[k] && !any) begin
            onehot[k] = 1'b1;
            any       = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
   import irq_seq_pkg::*;
#(
   parameter int          ADDR_W  = 16,
   parameter int unsigned VEC_TOP = 'h3FFE,
   parameter int          DSC_N   = 5,
   parameter int          TMR_N   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              insn_end,
   output logic              cpu_mask,
   input  logic              mask_clr,
   input  logic              rti_strobe,
   input  logic              rti_mask,
   input  logic              swi_req,
   input  logic              ext_pend,
   input  logic              ext_en,
   input  logic              sync_pend,
   input  logic              sync_en,
   input  logic [DSC_N-1:0]  disp_flags,
   input  logic [DSC_N-1:0]  disp_en,
   input  logic [TMR_N-1:0]  tmr_flags,
   input  logic [TMR_N-1:0]  tmr_en,
   output logic              stack_req,
   input  logic              stack_done,
   output logic              mask_set,
   output logic              vec_valid,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [NSRC-1:0]   grant
);
   localparam int unsigned VEC_LOW = VEC_TOP - 2 * (NSRC - 1);
   localparam logic [NSRC-1:0] RST_OH = NSRC'(1) << SRC_RST;
   localparam logic [NSRC-1:0] SWI_OH = NSRC'(1) << SRC_SWI;

   generate
      if (ADDR_W < 8) begin : g_bad_w
         $error("irq_vec_seq: ADDR_W too small");
      end
      if (VEC_TOP % 2 != 0) begin : g_bad_align
         $error("irq_vec_seq: VEC_TOP must be even");
      end
      if (VEC_TOP >= (64'd1 << ADDR_W) || VEC_TOP < 2 * (NSRC - 1)) begin : g_bad_range
         $error("irq_vec_seq: vector table does not fit the address width");
      end
   endgenerate

   seq_state_t      state;
   logic            mask_q;
   logic            swi_lat;
   logic [NSRC-1:0] lat_q;
   logic [NSRC-1:0] grant_q;
   logic            dsc_req, tmr_req;
   logic [NSRC-1:0] hw_req;
   logic [NSRC-1:0] pick_in, pick_oh;
   logic            pick_any;
   logic            take;
   logic [ADDR_W-1:0] base;

   irq_flag_merge #(.N(DSC_N)) u_dsc_merge (.flags(disp_flags), .en(disp_en), .req(dsc_req));
   irq_flag_merge #(.N(TMR_N)) u_tmr_merge (.flags(tmr_flags),  .en(tmr_en),  .req(tmr_req));

   always_comb begin
      hw_req          = '0;
      hw_req[SRC_EXT] = ext_pend & ext_en;
      hw_req[SRC_SYN] = sync_pend & sync_en;
      hw_req[SRC_DSC] = dsc_req;
      hw_req[SRC_TMR] = tmr_req;
   end

   // at the boundary the software request joins the hardware set; after
   // stacking a latched software request stands alone
   always_comb begin
      if (state == S_MASK) pick_in = swi_lat ? SWI_OH : hw_req;
      else                 pick_in = hw_req | (swi_req ? SWI_OH : '0);
   end

   irq_prio_pick #(.N(NSRC)) u_pick (.req(pick_in), .onehot(pick_oh), .any(pick_any));

   assign take = (state == S_IDLE) && insn_end && (swi_req || (!mask_q && (|hw_req)));

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= S_RST_HI;
         mask_q  <= 1'b1;
         swi_lat <= 1'b0;
         lat_q   <= RST_OH;
         grant_q <= RST_OH;
      end else begin
         case (state)
            S_RST_HI: state <= S_RST_LO;
            S_RST_LO: state <= S_IDLE;
            S_IDLE: begin
               if (take) begin
                  state   <= S_STACK;
                  lat_q   <= pick_oh;
                  swi_lat <= swi_req;
               end else if (rti_strobe) begin
                  mask_q <= rti_mask;
               end else if (mask_clr) begin
                  mask_q <= 1'b0;
               end
            end
            S_STACK: if (stack_done) state <= S_MASK;
            S_MASK: begin
               mask_q  <= 1'b1;
               grant_q <= pick_any ? pick_oh : lat_q;
               state   <= S_VEC_HI;
            end
            S_VEC_HI: state <= S_VEC_LO;
            S_VEC_LO: state <= S_IDLE;
            default:  state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      base = '0;
      for (int k = 0; k < NSRC; k++) begin
         if (grant_q[k]) base = ADDR_W'(VEC_TOP - 2 * k);
      end
   end

   assign cpu_mask  = mask_q;
   assign stack_req = (state == S_STACK);
   assign mask_set  = (state == S_MASK);
   assign vec_valid = (state == S_RST_HI) || (state == S_RST_LO) ||
                      (state == S_VEC_HI) || (state == S_VEC_LO);
   assign vec_addr  = base + ADDR_W'((state == S_RST_LO) || (state == S_VEC_LO));
   assign grant     = vec_valid ? grant_q : '0;

   // stacking starts only after an instruction boundary (R2)
   p_stack_on_boundary_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(stack_req) |-> $past(insn_end));

   // a hardware-only acceptance needs the mask clear (R3)
   p_hw_needs_mask_clear_r3: assert property (@(posedge clk) disable iff (rst)
      ($rose(stack_req) && !$past(swi_req)) |-> !$past(cpu_mask));

   // mask_set follows the cycle where stacking was reported done (R5)
   p_mask_set_after_done_r5: assert property (@(posedge clk) disable iff (rst)
      mask_set |-> $past(stack_req && stack_done));

   // one source granted while a vector is presented (R9)
   p_grant_onehot_r9: assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> ($countones(grant) == 1));

   // high byte address is followed by its pair with the same grant (R10)
   p_lo_follows_hi_r10: assert property (@(posedge clk) disable iff (rst)
      (vec_valid && !vec_addr[0]) |=> (vec_valid && vec_addr[0] && $stable(grant)));

   // mask stays set while vectoring (R12)
   p_mask_held_r12: assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> cpu_mask);
endmodule

// File: tb/irq_vec_seq_bench.sv
module irq_vec_seq_bench;
   typedef struct packed {
      logic        mask;
      logic        swi;
      logic        ep, ee, sp, se;
      logic [4:0]  df, de;
      logic [1:0]  tf, te;
      logic        take;
      logic [15:0] addr;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 5'h00,5'h00, 2'b00,2'b00, 1'b1,16'h3FFA},
      '{1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0, 5'h00,5'h00, 2'b00,2'b00, 1'b0,16'h0000},
      '{1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, 5'h00,5'h00, 2'b00,2'b00, 1'b1,16'h3FFC},
      '{1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 5'h00,5'h00, 2'b01,2'b01, 1'b1,16'h3FFA},
      '{1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h08,5'h08, 2'b00,2'b00, 1'b1,16'h3FF6},
      '{1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h08,5'h17, 2'b00,2'b00, 1'b0,16'h0000},
      '{1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h00,5'h00, 2'b10,2'b10, 1'b1,16'h3FF4},
      '{1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1, 5'h01,5'h01, 2'b00,2'b00, 1'b1,16'h3FF8},
      '{1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0, 5'h00,5'h00, 2'b00,2'b00, 1'b1,16'h3FFC},
      '{1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 5'h00,5'h00, 2'b01,2'b10, 1'b1,16'h3FF8}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic insn_end = 0, mask_clr = 0, rti_strobe = 0, rti_mask = 0, swi_req = 0;
   logic ext_pend = 0, ext_en = 0, sync_pend = 0, sync_en = 0, stack_done = 0;
   logic [4:0] disp_flags = '0, disp_en = '0;
   logic [1:0] tmr_flags = '0, tmr_en = '0;
   logic cpu_mask, stack_req, mask_set, vec_valid;
   logic [15:0] vec_addr;
   logic [5:0] grant;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_vec_seq u_irq_vec_seq (
      .clk(clk), .rst(rst), .insn_end(insn_end), .cpu_mask(cpu_mask),
      .mask_clr(mask_clr), .rti_strobe(rti_strobe), .rti_mask(rti_mask),
      .swi_req(swi_req), .ext_pend(ext_pend), .ext_en(ext_en),
      .sync_pend(sync_pend), .sync_en(sync_en), .disp_flags(disp_flags),
      .disp_en(disp_en), .tmr_flags(tmr_flags), .tmr_en(tmr_en),
      .stack_req(stack_req), .stack_done(stack_done), .mask_set(mask_set),
      .vec_valid(vec_valid), .vec_addr(vec_addr), .grant(grant));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_src();
      swi_req = 0; ext_pend = 0; ext_en = 0; sync_pend = 0; sync_en = 0;
      disp_flags = '0; disp_en = '0; tmr_flags = '0; tmr_en = '0;
   endtask

   task automatic set_mask(input logic m);
      @(negedge clk);
      if (m) begin rti_strobe = 1; rti_mask = 1; end
      else mask_clr = 1;
      @(negedge clk);
      rti_strobe = 0; rti_mask = 0; mask_clr = 0;
   endtask

   // caller sets flags; this raises insn_end for one edge and returns at the next negedge
   task automatic boundary();
      @(negedge clk);
      insn_end = 1;
      @(negedge clk);
      insn_end = 0;
   endtask

   // called at the negedge after the accepting edge
   task automatic finish_vec(input logic [15:0] addr, input string tag);
      int k = (16'h3FFE - addr) / 2;
      chk(stack_req === 1'b1, {tag, " R5 stack_req"}, stack_req, 1);
      stack_done = 1;
      @(negedge clk);
      stack_done = 0;
      chk(mask_set === 1'b1 && stack_req === 1'b0, {tag, " R5 mask_set"}, mask_set, 1);
      @(negedge clk);
      chk(vec_valid === 1'b1 && vec_addr === addr, {tag, " R9 high address"}, vec_addr, addr);
      chk(grant === 6'(1 << k), {tag, " R9 grant"}, grant, 6'(1 << k));
      chk(cpu_mask === 1'b1, {tag, " R12 mask set"}, cpu_mask, 1);
      @(negedge clk);
      chk(vec_valid === 1'b1 && vec_addr === addr + 16'd1, {tag, " R10 low address"}, vec_addr, addr + 16'd1);
      @(negedge clk);
      chk(vec_valid === 1'b0 && cpu_mask === 1'b1, {tag, " R12 idle masked"}, {vec_valid, cpu_mask}, 2'b01);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1 reset vectoring
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      chk(vec_valid === 1'b1 && vec_addr === 16'h3FFE, "R1 reset high", vec_addr, 16'h3FFE);
      chk(grant === 6'b000001 && cpu_mask === 1'b1, "R1 reset grant/mask", {grant, cpu_mask}, 7'b0000011);
      @(negedge clk);
      chk(vec_addr === 16'h3FFF && vec_valid === 1'b1, "R1 R10 reset low", vec_addr, 16'h3FFF);
      @(negedge clk);
      chk(vec_valid === 1'b0 && stack_req === 1'b0, "R1 reset done", vec_valid, 0);

      // table walk (R3 R4 R6 R8 R9)
      for (int i = 0; i < NV; i++) begin
         set_mask(TBL[i].mask);
         swi_req = TBL[i].swi; ext_pend = TBL[i].ep; ext_en = TBL[i].ee;
         sync_pend = TBL[i].sp; sync_en = TBL[i].se;
         disp_flags = TBL[i].df; disp_en = TBL[i].de;
         tmr_flags = TBL[i].tf; tmr_en = TBL[i].te;
         boundary();
         swi_req = 0;
         if (TBL[i].take) begin
            finish_vec(TBL[i].addr, $sformatf("vec%0d R4 R6 R8", i));
         end else begin
            chk(stack_req === 1'b0, $sformatf("vec%0d R3 R8 refused", i), stack_req, 0);
            @(negedge clk);
            chk(stack_req === 1'b0 && vec_valid === 1'b0, $sformatf("vec%0d R3 stays idle", i), stack_req, 0);
         end
         clear_src();
      end

      // R2 no action without insn_end
      set_mask(0);
      ext_pend = 1; ext_en = 1;
      repeat (4) @(negedge clk);
      chk(stack_req === 1'b0, "R2 no boundary", stack_req, 0);
      boundary();
      finish_vec(16'h3FFA, "R2 taken at boundary");
      clear_src();

      // R5 stack_req held while stacking is slow
      set_mask(0);
      tmr_flags = 2'b01; tmr_en = 2'b01;
      boundary();
      repeat (3) @(negedge clk);
      chk(stack_req === 1'b1 && mask_set === 1'b0, "R5 held", stack_req, 1);
      finish_vec(16'h3FF4, "R5 slow stack");
      clear_src();

      // R6 higher source arriving during stacking wins
      set_mask(0);
      tmr_flags = 2'b01; tmr_en = 2'b01;
      boundary();
      ext_pend = 1; ext_en = 1;
      finish_vec(16'h3FFA, "R6 late arrival");
      clear_src();

      // R7 winner dropped during stacking, lower one remains
      set_mask(0);
      ext_pend = 1; ext_en = 1; tmr_flags = 2'b10; tmr_en = 2'b10;
      boundary();
      ext_pend = 0;
      finish_vec(16'h3FF4, "R7 dropped winner");
      clear_src();

      // R7 everything dropped: latched source used
      set_mask(0);
      sync_pend = 1; sync_en = 1; disp_flags = 5'h10; disp_en = 5'h10;
      boundary();
      clear_src();
      finish_vec(16'h3FF8, "R7 latched fallback");

      // R4 software interrupt with mask set and hardware pending
      set_mask(1);
      ext_pend = 1; ext_en = 1; swi_req = 1;
      boundary();
      swi_req = 0;
      finish_vec(16'h3FFC, "R4 swi masked");
      clear_src();

      // R11 return restores stacked mask, clear strobe unmasks
      set_mask(0);
      chk(cpu_mask === 1'b0, "R11 mask cleared", cpu_mask, 0);
      @(negedge clk); rti_strobe = 1; rti_mask = 1;
      @(negedge clk); rti_strobe = 0; rti_mask = 0;
      chk(cpu_mask === 1'b1, "R11 rti restores 1", cpu_mask, 1);
      @(negedge clk); rti_strobe = 1; rti_mask = 0;
      @(negedge clk); rti_strobe = 0;
      chk(cpu_mask === 1'b0, "R11 rti restores 0", cpu_mask, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule